// File: doc/BRIEF.md
# Memory-Mapped Flash Prefetch Session Controller

This block manages the lifetime of a read session toward an external serial flash that is mapped into the address space. Reads arrive from a simple request bus. Each one is checked against the configured flash capacity. A valid read either continues the current sequential prefetch stream or starts a new stream. While a stream is open, chip select stays asserted and a shifting engine (outside this block) pushes prefetched words into a local buffer. The block tracks how full that buffer is.

When the buffer reaches capacity, an idle counter starts. If the programmed number of cycles passes with no accepted read, the block stops the engine, raises chip select and drops busy. Busy rises with the first accepted read. It falls only on this timeout, on an abort, or when the block is disabled. The engine is controlled by single-cycle start and stop pulses, which carry the stream's start address.

Top module: `xip_session_ctrl`

## Requirements
- R1: After reset, cs_n is 1, busy is 0, eng_start, eng_stop and rsp_valid are 0, and req_ready is 1.
- R2: A request is in range when req_addr < 2^min(cfg_fsize+1, 28); the 28-bit cap is the 256 MB mapped window, and cfg_fsize describes the total capacity even when two devices share the bus. The cycle after an accepted out-of-range request, rsp_valid=1 and rsp_err=1, with no eng_start and no change to cs_n or busy.
- R3: While the block is enabled, the cycle after an in-range request is accepted, rsp_valid=1 and rsp_err=0.
- R4: An in-range request accepted while no session is open gives, on the next cycle, eng_start=1 for one cycle, eng_addr equal to the request address, cs_n=0 and busy=1.
- R5: An accepted request whose address equals the previous stream address plus 4 (a hit) produces no eng_start and no eng_stop, and cs_n stays 0.
- R6: An accepted in-range request at any other address while the session is open gives eng_stop=1 and cs_n=1 for exactly one cycle, with req_ready=0 in that cycle. On the following cycle, eng_start=1, eng_addr holds the new address and cs_n=0.
- R7: eng_push raises the buffer fill level by one, up to FIFO_DEPTH (4). Each hit lowers it by one. The level is emptied whenever a session ends or restarts.
- R8: With cfg_timeout=T>0, cs_n rises together with a one-cycle eng_stop pulse and busy falls exactly T clock edges after the edge on which the fill level reached FIFO_DEPTH, provided no request was accepted in between.
- R9: An accepted request before expiry clears the idle count. After that, the full T-cycle window is measured again from the next time the buffer becomes full.
- R10: cfg_timeout=0 never releases the session.
- R11: abort_req forces req_ready to 0 in its cycle. On the next cycle, cs_n=1 and busy=0, with one eng_stop pulse if chip select had been asserted.
- R12: With cfg_enable=0, an open session ends on the next cycle (cs_n=1, busy=0, eng_stop pulse), and every accepted request gets rsp_err=1 and never starts a session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Block enable |
| cfg_fsize | input | 5 | Flash capacity code: 2^(cfg_fsize+1) bytes |
| cfg_timeout | input | 16 | Idle cycles before release; 0 disables release |
| abort_req | input | 1 | Abort the current session |
| req_valid | input | 1 | Read request valid |
| req_addr | input | 32 | Read request byte address |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_err | output | 1 | Response is an error |
| eng_push | input | 1 | Engine pushed one prefetched word |
| eng_start | output | 1 | Start pulse to the shifting engine |
| eng_stop | output | 1 | Stop pulse to the shifting engine |
| eng_addr | output | 32 | Stream start address for the engine |
| cs_n | output | 1 | Flash chip select, active low |
| busy | output | 1 | Session in progress |

## Verification
Some relations are checked on every cycle. These are: chip select is never asserted without busy; start and stop never pulse together; chip select edges always coincide with the matching engine pulse; abort and disable clear busy on the next cycle; busy rises only after an accepted request; and requests above the 256 MB window or made while disabled are answered with an error. Other behaviour can only be shown by the bench's scenarios. That includes the exact cycle on which the idle timeout expires, relative to the buffer becoming full. It also includes the restart of that count by a hit, the value zero never releasing, and the one-cycle gap between stop and start on a stream miss. The bench also checks the range decision for each capacity code against its own model, using random addresses.

// File: rtl/xip_pkg.sv
package xip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } xip_state_e;
endpackage

// File: rtl/xip_addr_check.sv
module xip_addr_check #(
  parameter int ADDR_W   = 32,
  parameter int FSIZE_W  = 5,
  parameter int WIN_BITS = 28
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FSIZE_W-1:0] fsize,
  output logic               in_range
);
  localparam int EFF_W = FSIZE_W + 1;

  logic [EFF_W-1:0]  bits_cfg;
  logic [EFF_W-1:0]  bits_eff;
  logic [ADDR_W-1:0] hi_mask;

  always_comb begin
    bits_cfg = {1'b0, fsize} + EFF_W'(1);
    bits_eff = (bits_cfg > EFF_W'(WIN_BITS)) ? EFF_W'(WIN_BITS) : bits_cfg;
  end

  // Bit g of the address must be clear when g is at or above the capacity width.
  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign hi_mask[g] = (bits_eff <= EFF_W'(g));
  end

  assign in_range = ~|(addr & hi_mask);
endmodule

// File: rtl/xip_fill_track.sv
module xip_fill_track #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push,
  input  logic pop,
  output logic full
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

  logic [LVL_W-1:0] level_q, level_n;
  logic             push_ok, pop_ok;

  assign push_ok = push && (level_q != LVL_MAX);
  assign pop_ok  = pop && (level_q != '0);

  always_comb begin
    level_n = level_q;
    if (flush) begin
      level_n = '0;
    end else begin
      unique case ({push_ok, pop_ok})
        2'b10:   level_n = level_q + LVL_W'(1);
        2'b01:   level_n = level_q - LVL_W'(1);
        default: level_n = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (flush || push_ok || pop_ok) begin
      level_q <= level_n;
    end
  end

  assign full = (level_q == LVL_MAX);
endmodule

// File: rtl/xip_idle_timer.sv
module xip_idle_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W-1:0] cnt_q, cnt_n;

  assign cnt_n  = run ? (cnt_q + TO_W'(1)) : '0;
  assign expire = run && (limit != '0) && (cnt_q == (limit - TO_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run || (cnt_q != '0)) begin
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/xip_session_fsm.sv
module xip_session_fsm
  import xip_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              abort_req,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              in_range,
  input  logic              expire,
  output logic              active,
  output logic              acc,
  output logic              hit,
  output logic              flush,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              eng_start,
  output logic              eng_stop,
  output logic [ADDR_W-1:0] eng_addr,
  output logic              cs_n,
  output logic              busy
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  xip_state_e        state_q, state_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n, eaddr_q, eaddr_n;
  logic              start_q, start_n, stop_q, stop_n;
  logic              rv_q, re_q, err;

  assign req_ready = (state_q != ST_GAP) && !abort_req;
  assign acc       = req_valid && req_ready && cfg_enable && in_range;
  assign err       = req_valid && req_ready && !(cfg_enable && in_range);
  assign active    = (state_q == ST_ACTIVE);

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    eaddr_n = eaddr_q;
    start_n = 1'b0;
    stop_n  = 1'b0;
    hit     = 1'b0;
    if (!cfg_enable || abort_req) begin
      stop_n  = (state_q == ST_ACTIVE);
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc) begin
            state_n = ST_ACTIVE;
            start_n = 1'b1;
            eaddr_n = req_addr;
            ptr_n   = req_addr + STEP;
          end
        end
        ST_ACTIVE: begin
          if (acc) begin
            if (req_addr == ptr_q) begin
              hit   = 1'b1;
              ptr_n = ptr_q + STEP;
            end else begin
              stop_n  = 1'b1;
              state_n = ST_GAP;
              eaddr_n = req_addr;
            end
          end else if (expire) begin
            stop_n  = 1'b1;
            state_n = ST_IDLE;
          end
        end
        ST_GAP: begin
          state_n = ST_ACTIVE;
          start_n = 1'b1;
          ptr_n   = eaddr_q + STEP;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  assign flush = (state_q != ST_ACTIVE) || (state_n != ST_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      rv_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      start_q <= start_n;
      stop_q  <= stop_n;
      rv_q    <= acc || err;
      re_q    <= err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      eaddr_q <= '0;
    end else if (state_n != state_q || hit) begin
      ptr_q   <= ptr_n;
      eaddr_q <= eaddr_n;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_err   = re_q;
  assign eng_start = start_q;
  assign eng_stop  = stop_q;
  assign eng_addr  = eaddr_q;
  assign cs_n      = (state_q != ST_ACTIVE);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/xip_session_ctrl.sv
module xip_session_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int FSIZE_W    = 5,
  parameter int TO_W       = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int WORD_BYTES = 4,
  parameter int WIN_BITS   = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [FSIZE_W-1:0] cfg_fsize,
  input  logic [TO_W-1:0]    cfg_timeout,
  input  logic               abort_req,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic               rsp_err,
  input  logic               eng_push,
  output logic               eng_start,
  output logic               eng_stop,
  output logic [ADDR_W-1:0]  eng_addr,
  output logic               cs_n,
  output logic               busy
);
  logic rst_meta_q, rst_sync_q;
  logic in_range, expire, active, acc, hit, flush, full;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  xip_addr_check #(
    .ADDR_W(ADDR_W), .FSIZE_W(FSIZE_W), .WIN_BITS(WIN_BITS)
  ) u_range (
    .addr(req_addr), .fsize(cfg_fsize), .in_range(in_range)
  );

  xip_fill_track #(.DEPTH(FIFO_DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_sync_q), .flush(flush),
    .push(eng_push && active), .pop(hit), .full(full)
  );

  xip_idle_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_q),
    .run(active && full && !acc), .limit(cfg_timeout), .expire(expire)
  );

  xip_session_fsm #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_sync_q), .cfg_enable(cfg_enable),
    .abort_req(abort_req), .req_valid(req_valid), .req_addr(req_addr),
    .in_range(in_range), .expire(expire), .active(active), .acc(acc),
    .hit(hit), .flush(flush), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .eng_start(eng_start), .eng_stop(eng_stop),
    .eng_addr(eng_addr), .cs_n(cs_n), .busy(busy)
  );
endmodule

// File: rtl/xip_session_sva.sv
module xip_session_sva #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              abort_req,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              eng_start,
  input logic              eng_stop,
  input logic              cs_n,
  input logic              busy
);
  // R4: chip select low only inside a busy session
  a_r4_cs_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R4: busy rises only after an accepted request
  a_r4_busy_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  // R6: engine never told to start and stop at once
  a_r6_no_start_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_start && eng_stop));

  // R8: chip select release always carries the stop pulse
  a_r8_release_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> eng_stop);

  // R6: chip select assertion always carries the start pulse
  a_r6_assert_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> eng_start);

  // R11: abort ends the session next cycle
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!busy && cs_n));

  // R12: disable ends the session next cycle
  a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!busy && cs_n));

  // R12: requests while disabled are errored
  a_r12_disabled_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_enable) |=> (rsp_valid && rsp_err));

  // R2: anything above the mapped window is errored
  a_r2_window_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (|req_addr[ADDR_W-1:WIN_BITS]))
      |=> (rsp_valid && rsp_err));
endmodule

bind xip_session_ctrl xip_session_sva #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .abort_req(abort_req),
  .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .eng_start(eng_start),
  .eng_stop(eng_stop), .cs_n(cs_n), .busy(busy)
);

// File: tb/xip_session_ctrl_test.sv
module xip_session_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_enable;
  logic [4:0]  cfg_fsize;
  logic [15:0] cfg_timeout;
  logic        abort_req;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        rsp_valid;
  logic        rsp_err;
  logic        eng_push;
  logic        eng_start;
  logic        eng_stop;
  logic [31:0] eng_addr;
  logic        cs_n;
  logic        busy;

  int n_chk;
  int n_fail;
  int seed;

  xip_session_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_fsize(cfg_fsize),
    .cfg_timeout(cfg_timeout), .abort_req(abort_req), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .eng_push(eng_push), .eng_start(eng_start),
    .eng_stop(eng_stop), .eng_addr(eng_addr), .cs_n(cs_n), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_in_range(input logic [31:0] a, input logic [4:0] fs);
    int bits;
    bits = int'(fs) + 1;
    if (bits > 28) bits = 28;
    return (a >> bits) == 32'd0;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_abort();
    abort_req = 1'b1;
    step();
    abort_req = 1'b0;
  endtask

  task automatic request(input logic [31:0] a);
    req_valid = 1'b1;
    req_addr  = a;
    step();
    req_valid = 1'b0;
  endtask

  task automatic push_n(input int n);
    eng_push = 1'b1;
    for (int i = 0; i < n; i++) step();
    eng_push = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; seed = 1234;
    void'($urandom(seed));
    rst_n = 1'b0; cfg_enable = 1'b1; cfg_fsize = 5'd20; cfg_timeout = 16'd0;
    abort_req = 1'b0; req_valid = 1'b0; req_addr = '0; eng_push = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 cs_n", cs_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 eng_start", eng_start, 0);
    chk("R1 eng_stop", eng_stop, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);

    // R2 out of range with fsize 20 (2 MB)
    request(32'h0020_0000);
    chk("R2 rsp_valid", rsp_valid, 1);
    chk("R2 rsp_err", rsp_err, 1);
    chk("R2 no start", eng_start, 0);
    chk("R2 cs_n", cs_n, 1);
    chk("R2 busy", busy, 0);

    // R2 window cap: fsize 31 still limited to 256 MB
    cfg_fsize = 5'd31;
    request(32'h1000_0000);
    chk("R2 cap err", rsp_err, 1);
    chk("R2 cap busy", busy, 0);
    request(32'h0FFF_FFF0);
    chk("R2 cap top ok", rsp_err, 0);
    chk("R4 cap start", eng_start, 1);
    do_abort();
    cfg_fsize = 5'd20;

    // R3/R4 first access
    request(32'h0000_0100);
    chk("R3 rsp_valid", rsp_valid, 1);
    chk("R3 rsp_err", rsp_err, 0);
    chk("R4 eng_start", eng_start, 1);
    chk("R4 eng_addr", eng_addr, 32'h100);
    chk("R4 cs_n", cs_n, 0);
    chk("R4 busy", busy, 1);
    step();
    chk("R4 start one cycle", eng_start, 0);

    // R5 sequential hits
    request(32'h0000_0104);
    chk("R5 no start", eng_start, 0);
    chk("R5 no stop", eng_stop, 0);
    chk("R5 cs_n", cs_n, 0);
    request(32'h0000_0108);
    chk("R5 second hit cs_n", cs_n, 0);
    chk("R5 second hit stop", eng_stop, 0);

    // R6 stream miss
    request(32'h0000_0400);
    chk("R6 stop", eng_stop, 1);
    chk("R6 cs_n gap", cs_n, 1);
    chk("R6 ready low", req_ready, 0);
    chk("R6 busy held", busy, 1);
    step();
    chk("R6 restart", eng_start, 1);
    chk("R6 new addr", eng_addr, 32'h400);
    chk("R6 cs_n back", cs_n, 0);

    // R10 timeout zero holds the session
    push_n(4);
    for (int i = 0; i < 40; i++) step();
    chk("R10 cs_n held", cs_n, 0);
    chk("R10 busy held", busy, 1);

    // R11 abort
    abort_req = 1'b1;
    #1;
    chk("R11 ready low", req_ready, 0);
    step();
    abort_req = 1'b0;
    chk("R11 stop", eng_stop, 1);
    chk("R11 cs_n", cs_n, 1);
    chk("R11 busy", busy, 0);

    // R7/R8 timeout from full
    cfg_timeout = 16'd5;
    request(32'h0000_0200);
    push_n(3);
    for (int i = 0; i < 8; i++) step();
    chk("R7 not full no release", cs_n, 0);
    push_n(1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R8 before expiry", cs_n, 0);
    end
    step();
    chk("R8 release cs_n", cs_n, 1);
    chk("R8 release stop", eng_stop, 1);
    chk("R8 release busy", busy, 0);

    // R4 access after release restarts even at stream address
    request(32'h0000_0204);
    chk("R4 restart after release", eng_start, 1);

    // R9 hit restarts the idle window
    push_n(4);
    step(); step();
    request(32'h0000_0208);
    chk("R9 hit no stop", eng_stop, 0);
    push_n(1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 window restarted", cs_n, 0);
    end
    step();
    chk("R9 release", cs_n, 1);

    // R7 pushes above depth are dropped; a hit leaves room again
    cfg_timeout = 16'd3;
    request(32'h0000_0300);
    push_n(6);
    request(32'h0000_0304);
    for (int i = 0; i < 6; i++) step();
    chk("R7 level below depth", cs_n, 0);
    push_n(1);
    step(); step();
    chk("R7 refilled before expiry", cs_n, 0);
    step();
    chk("R7 refilled expiry", cs_n, 1);
    cfg_timeout = 16'd0;

    // R12 disable
    request(32'h0000_0500);
    cfg_enable = 1'b0;
    step();
    chk("R12 stop", eng_stop, 1);
    chk("R12 cs_n", cs_n, 1);
    chk("R12 busy", busy, 0);
    request(32'h0000_0600);
    chk("R12 error", rsp_err, 1);
    chk("R12 no start", eng_start, 0);
    chk("R12 still idle", busy, 0);
    cfg_enable = 1'b1;
    step();

    // R2/R3 random range checks
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      logic        inr;
      cfg_fsize = 5'($urandom % 32);
      a = $urandom >> ($urandom % 32);
      inr = exp_in_range(a, cfg_fsize);
      request(a);
      chk("R2 random err", rsp_err, !inr);
      chk("R3 random valid", rsp_valid, 1);
      chk("R4 random busy", busy, inr);
      if (inr) begin
        do_abort();
        chk("R11 random abort", busy, 0);
      end
    end

    finish_run();
  end
endmodule